// File: doc/BRIEF.md
# Tag-Steered Aliased Memory Controller

This block gathers a small set of on-chip RAMs that a single runtime pointer may refer to. Each pointer carries a memory tag in its upper bits and a word offset in its lower bits. On every access the tag turns on exactly one RAM. A copy of that tag travels down the pipeline beside the read. Two cycles later it drives the output multiplexer that picks which RAM's read data goes back to the requester.

Two independent access ports are provided. Each port has an enable, a write enable, a pointer, write data, a read-valid flag and read data. Both ports can be served in the same clock cycle, whether they target the same RAM or different ones. The first stage registers the request. The second stage is the synchronous RAM access. Read data is therefore always returned a fixed two cycles after the request.

The RAMs have different depths. Memory m holds `MAX_DEPTH >> m` words. A pointer whose tag names no memory, or whose offset lies past the end of the tagged memory, never touches any RAM. When the port count is set to one, each RAM is built with a single access port.

Top module: `amc_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no request issued, `rsp_valid` is low and `rsp_rdata` is zero on both ports.
- R2: A pointer splits into a tag in bits [PTR_W-1:OFS_W] and an offset in bits [OFS_W-1:0]. With the defaults, TAG_W=2, OFS_W=4 and PTR_W=6. Memory m has a depth of MAX_DEPTH>>m, which is 16, 8 and 4 words for tags 0, 1 and 2.
- R3: An access enables only the memory named by its tag. The contents of every other memory stay unchanged.
- R4: Read data comes from the memory named by the tag of that read request. This holds even when the requests that follow on the same port carry different tags.
- R5: A read request sampled at clock edge k raises `rsp_valid` on that port after edge k+1, for exactly one cycle. Write requests and idle cycles never raise `rsp_valid`.
- R6: `rsp_rdata` is zero on any port whose `rsp_valid` is low.
- R7: The two ports operate independently in the same cycle, with any mix of reads, writes and tags, including both ports on the same memory.
- R8: When one port writes a pointer and the other port reads the same pointer in the same cycle, the read returns the data held before the write. The write still takes effect.
- R9: When both ports write the same pointer in the same cycle, the value from port 1 is the one kept.
- R10: A write whose offset is at or beyond the depth of the tagged memory changes no memory. A read with such an offset returns zero with `rsp_valid` high.
- R11: A write whose tag is NUM_MEMS or larger (tag 3 with the defaults) changes no memory. A read with such a tag returns zero with `rsp_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_en | input | NUM_PORTS | Per-port access request |
| req_we | input | NUM_PORTS | Per-port write enable (1 = write, 0 = read) |
| req_ptr | input | NUM_PORTS x PTR_W | Per-port pointer: tag in the upper field, offset in the lower field |
| req_wdata | input | NUM_PORTS x DATA_W | Per-port write data |
| rsp_valid | output | NUM_PORTS | Per-port read data valid, two cycles after a read request |
| rsp_rdata | output | NUM_PORTS x DATA_W | Per-port read data, zero when not valid |

## Verification
The bench first writes every pointer value from one port. This covers in-range slots, offsets past the shorter memories and the unused tag. It then reads every pointer from both ports in a plain sweep, and separately in an order where the tag changes every cycle. A wrong delayed tag shows up in the second sweep as data taken from the neighbouring memory. Targeted same-pointer cycles pair write/read and write/write across the ports, which separates read-before-write from read-after-write and shows which port wins a write collision. A long pseudo-random mix with forced pointer collisions follows, with every response compared against a per-memory reference model.

// File: rtl/amc_pkg.sv
package amc_pkg;

    // Number of words held by memory idx; never less than one.
    function automatic int unsigned mem_depth(input int unsigned max_depth,
                                              input int unsigned idx);
        int unsigned d;
        d = max_depth >> idx;
        return (d == 0) ? 1 : d;
    endfunction

    // Address bits needed for a memory of the given depth; at least one.
    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/amc_tag_decode.sv
module amc_tag_decode #(
    parameter int NUM_MEMS  = 3,
    parameter int MAX_DEPTH = 16,
    parameter int TAG_W     = 2,
    parameter int OFS_W     = 4
) (
    input  logic                vld,
    input  logic [TAG_W-1:0]    tag,
    input  logic [OFS_W-1:0]    ofs,
    output logic [NUM_MEMS-1:0] sel,
    output logic                hit
);
    import amc_pkg::*;

    always_comb begin
        sel = '0;
        for (int m = 0; m < NUM_MEMS; m++) begin
            if (vld && (tag == TAG_W'(m)) &&
                ({1'b0, ofs} < (OFS_W+1)'(mem_depth(MAX_DEPTH, m)))) begin
                sel[m] = 1'b1;
            end
        end
        hit = |sel;
    end

endmodule

// File: rtl/amc_bank.sv
module amc_bank #(
    parameter int DEPTH     = 16,
    parameter int NUM_PORTS = 2,
    parameter int DATA_W    = 8,
    parameter int AW        = 4
) (
    input  logic                              clk,
    input  logic [NUM_PORTS-1:0]              en,
    input  logic [NUM_PORTS-1:0]              we,
    input  logic [NUM_PORTS-1:0][AW-1:0]      addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]  wdata,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]  rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    generate
        if (NUM_PORTS == 1) begin : g_single
            // One access per cycle: a plain single-port array.
            always_ff @(posedge clk) begin
                if (en[0]) begin
                    rdata[0] <= mem[addr[0]];
                    if (we[0]) begin
                        mem[addr[0]] <= wdata[0];
                    end
                end
            end
        end else begin : g_multi
            // Every port reads the stored word before any write of this edge;
            // on a write clash the highest-numbered port is applied last.
            always_ff @(posedge clk) begin
                for (int p = 0; p < NUM_PORTS; p++) begin
                    if (en[p]) begin
                        rdata[p] <= mem[addr[p]];
                        if (we[p]) begin
                            mem[addr[p]] <= wdata[p];
                        end
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/amc_read_mux.sv
module amc_read_mux #(
    parameter int NUM_MEMS = 3,
    parameter int TAG_W    = 2,
    parameter int DATA_W   = 8
) (
    input  logic [NUM_MEMS-1:0][DATA_W-1:0] bank_data,
    input  logic [TAG_W-1:0]                tag,
    input  logic                            take,
    output logic [DATA_W-1:0]               dout
);

    always_comb begin
        dout = '0;
        if (take) begin
            for (int m = 0; m < NUM_MEMS; m++) begin
                if (tag == TAG_W'(m)) begin
                    dout = bank_data[m];
                end
            end
        end
    end

endmodule

// File: rtl/amc_ctrl.sv
module amc_ctrl #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_MEMS  = 3,
    parameter int MAX_DEPTH = 16,
    parameter int DATA_W    = 8,
    localparam int TAG_W    = (NUM_MEMS > 1) ? $clog2(NUM_MEMS) : 1,
    localparam int OFS_W    = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1,
    localparam int PTR_W    = TAG_W + OFS_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PORTS-1:0]             req_en,
    input  logic [NUM_PORTS-1:0]             req_we,
    input  logic [NUM_PORTS-1:0][PTR_W-1:0]  req_ptr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] req_wdata,
    output logic [NUM_PORTS-1:0]             rsp_valid,
    output logic [NUM_PORTS-1:0][DATA_W-1:0] rsp_rdata
);
    import amc_pkg::*;

    // Stage 1: the registered request.
    typedef struct packed {
        logic              vld;
        logic              we;
        logic [TAG_W-1:0]  tag;
        logic [OFS_W-1:0]  ofs;
        logic [DATA_W-1:0] wdata;
    } s1_t;

    // Stage 2: what the output mux needs alongside the RAM read.
    typedef struct packed {
        logic             rvld;
        logic             hit;
        logic [TAG_W-1:0] tag;
    } s2_t;

    typedef struct packed {
        s1_t [NUM_PORTS-1:0] s1;
        s2_t [NUM_PORTS-1:0] s2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [NUM_PORTS-1:0][NUM_MEMS-1:0]             port_sel;
    logic [NUM_PORTS-1:0]                           port_hit;
    logic [NUM_MEMS-1:0][NUM_PORTS-1:0][DATA_W-1:0] bank_rd;
    logic [NUM_PORTS-1:0][NUM_MEMS-1:0][DATA_W-1:0] port_rd;

    // Tag and range decode on the registered request.
    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
            amc_tag_decode #(
                .NUM_MEMS (NUM_MEMS),
                .MAX_DEPTH(MAX_DEPTH),
                .TAG_W    (TAG_W),
                .OFS_W    (OFS_W)
            ) u_dec (
                .vld(pipe_q.s1[p].vld),
                .tag(pipe_q.s1[p].tag),
                .ofs(pipe_q.s1[p].ofs),
                .sel(port_sel[p]),
                .hit(port_hit[p])
            );
        end
    endgenerate

    // One RAM per tag value; each is as deep as its own slot count.
    generate
        for (genvar m = 0; m < NUM_MEMS; m++) begin : g_bank
            localparam int DEP = mem_depth(MAX_DEPTH, m);
            localparam int AW  = addr_bits(DEP);

            logic [NUM_PORTS-1:0]             b_en;
            logic [NUM_PORTS-1:0]             b_we;
            logic [NUM_PORTS-1:0][AW-1:0]     b_addr;
            logic [NUM_PORTS-1:0][DATA_W-1:0] b_wd;
            logic [NUM_PORTS-1:0][DATA_W-1:0] b_rd;

            always_comb begin
                for (int p = 0; p < NUM_PORTS; p++) begin
                    b_en[p]   = port_sel[p][m];
                    b_we[p]   = pipe_q.s1[p].we;
                    b_addr[p] = pipe_q.s1[p].ofs[AW-1:0];
                    b_wd[p]   = pipe_q.s1[p].wdata;
                end
            end

            amc_bank #(
                .DEPTH    (DEP),
                .NUM_PORTS(NUM_PORTS),
                .DATA_W   (DATA_W),
                .AW       (AW)
            ) u_bank (
                .clk  (clk),
                .en   (b_en),
                .we   (b_we),
                .addr (b_addr),
                .wdata(b_wd),
                .rdata(b_rd)
            );

            assign bank_rd[m] = b_rd;
        end
    endgenerate

    // Regroup bank outputs by port for the per-port multiplexers.
    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int m = 0; m < NUM_MEMS; m++) begin
                port_rd[p][m] = bank_rd[m][p];
            end
        end
    end

    // Next-state computation for both pipeline stages.
    always_comb begin
        pipe_d = pipe_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            pipe_d.s1[p].vld   = req_en[p];
            pipe_d.s1[p].we    = req_we[p];
            pipe_d.s1[p].tag   = req_ptr[p][PTR_W-1:OFS_W];
            pipe_d.s1[p].ofs   = req_ptr[p][OFS_W-1:0];
            pipe_d.s1[p].wdata = req_wdata[p];

            pipe_d.s2[p].rvld  = pipe_q.s1[p].vld & ~pipe_q.s1[p].we;
            pipe_d.s2[p].hit   = port_hit[p];
            pipe_d.s2[p].tag   = pipe_q.s1[p].tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    // Output select driven by the tag that travelled with the read.
    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_out
            amc_read_mux #(
                .NUM_MEMS(NUM_MEMS),
                .TAG_W   (TAG_W),
                .DATA_W  (DATA_W)
            ) u_mux (
                .bank_data(port_rd[p]),
                .tag      (pipe_q.s2[p].tag),
                .take     (pipe_q.s2[p].rvld & pipe_q.s2[p].hit),
                .dout     (rsp_rdata[p])
            );
            assign rsp_valid[p] = pipe_q.s2[p].rvld;
        end
    endgenerate

endmodule

// File: rtl/amc_ctrl_chk.sv
module amc_ctrl_chk #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_MEMS  = 3,
    parameter int MAX_DEPTH = 16,
    parameter int DATA_W    = 8,
    localparam int TAG_W    = (NUM_MEMS > 1) ? $clog2(NUM_MEMS) : 1,
    localparam int OFS_W    = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1,
    localparam int PTR_W    = TAG_W + OFS_W
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_PORTS-1:0]             req_en,
    input logic [NUM_PORTS-1:0]             req_we,
    input logic [NUM_PORTS-1:0][PTR_W-1:0]  req_ptr,
    input logic [NUM_PORTS-1:0]             rsp_valid,
    input logic [NUM_PORTS-1:0][DATA_W-1:0] rsp_rdata,
    input logic [NUM_PORTS-1:0][NUM_MEMS-1:0] port_sel
);
    import amc_pkg::*;

    // Edges seen since reset release, saturating; gates $past look-backs.
    logic [1:0] live_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_cnt <= '0;
        end else if (live_cnt != 2'd3) begin
            live_cnt <= live_cnt + 2'd1;
        end
    end

    logic [NUM_PORTS-1:0] bad_tag;
    logic [NUM_PORTS-1:0] bad_ofs;
    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            bad_tag[p] = req_en[p] && (int'(req_ptr[p][PTR_W-1:OFS_W]) >= NUM_MEMS);
            bad_ofs[p] = req_en[p] && !bad_tag[p] &&
                         (int'(req_ptr[p][OFS_W-1:0]) >=
                          int'(mem_depth(MAX_DEPTH, int'(req_ptr[p][PTR_W-1:OFS_W]))));
        end
    end

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
            // R5
            latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (live_cnt >= 2'd2) |-> (rsp_valid[p] == $past(req_en[p] & ~req_we[p], 2)));

            // R6
            idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !rsp_valid[p] |-> (rsp_rdata[p] == '0));

            // R3
            sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(port_sel[p]));

            // R11
            bad_tag_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ((live_cnt >= 2'd1) && $past(bad_tag[p])) |-> (port_sel[p] == '0));

            // R10
            bad_ofs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ((live_cnt >= 2'd1) && $past(bad_ofs[p])) |-> (port_sel[p] == '0));
        end
    endgenerate

endmodule

bind amc_ctrl amc_ctrl_chk #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_MEMS (NUM_MEMS),
    .MAX_DEPTH(MAX_DEPTH),
    .DATA_W   (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_en   (req_en),
    .req_we   (req_we),
    .req_ptr  (req_ptr),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .port_sel (port_sel)
);

// File: tb/amc_ctrl_bench.sv
`timescale 1ns/1ps
module amc_ctrl_bench;

    localparam int NP = 2;
    localparam int NM = 3;
    localparam int MD = 16;
    localparam int DW = 8;
    localparam int PW = 6;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NP-1:0]          req_en = '0;
    logic [NP-1:0]          req_we = '0;
    logic [NP-1:0][PW-1:0]  req_ptr = '0;
    logic [NP-1:0][DW-1:0]  req_wdata = '0;
    logic [NP-1:0]          rsp_valid;
    logic [NP-1:0][DW-1:0]  rsp_rdata;

    always #4 clk = ~clk;   // 125 MHz

    amc_ctrl u_amc_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_en   (req_en),
        .req_we   (req_we),
        .req_ptr  (req_ptr),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [DW-1:0] ref_mem [NM][MD];

    // Expected responses: stage 1 = issued last negedge, stage 2 = due now.
    logic          e1_v [NP];
    logic [DW-1:0] e1_d [NP];
    string         e1_l [NP];
    logic          e2_v [NP];
    logic [DW-1:0] e2_d [NP];
    string         e2_l [NP];

    logic [15:0] lf = 16'hACE1;

    function automatic int depth_of(input int t);
        return MD >> t;
    endfunction

    task automatic fail(input string lbl, input int p, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
        n_bad++;
        $display("FAIL %s port %0d: actual %0h expected %0h at %0t", lbl, p, act, exp, $time);
    endtask

    task automatic chk_out();
        for (int p = 0; p < NP; p++) begin
            n_cmp++;
            if (rsp_valid[p] !== e2_v[p]) fail("R5 valid", p, DW'(rsp_valid[p]), DW'(e2_v[p]));
            n_cmp++;
            if (e2_v[p]) begin
                if (rsp_rdata[p] !== e2_d[p]) fail(e2_l[p], p, rsp_rdata[p], e2_d[p]);
            end else begin
                if (rsp_rdata[p] !== '0) fail("R6 idle data", p, rsp_rdata[p], '0);
            end
        end
    endtask

    // Called just after a negedge: check due outputs, issue a request, advance.
    task automatic step(input logic [1:0] en, input logic [1:0] we,
                        input logic [PW-1:0] p0, input logic [PW-1:0] p1,
                        input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                        input string l0, input string l1);
        logic [PW-1:0] pp [NP];
        logic [DW-1:0] dd [NP];
        int t, o;
        bit ok;
        pp[0] = p0; pp[1] = p1; dd[0] = d0; dd[1] = d1;
        chk_out();
        for (int p = 0; p < NP; p++) begin
            e2_v[p] = e1_v[p]; e2_d[p] = e1_d[p]; e2_l[p] = e1_l[p];
        end
        for (int p = 0; p < NP; p++) begin
            t  = int'(pp[p][5:4]);
            o  = int'(pp[p][3:0]);
            ok = (t < NM) && (o < depth_of(t));
            e1_v[p] = en[p] & ~we[p];
            e1_d[p] = ok ? ref_mem[t][o] : '0;
            if (!ok) e1_l[p] = (t >= NM) ? "R11 bad tag read" : "R10 bad offset read";
            else     e1_l[p] = (p == 0) ? l0 : l1;
        end
        for (int p = 0; p < NP; p++) begin
            t  = int'(pp[p][5:4]);
            o  = int'(pp[p][3:0]);
            ok = (t < NM) && (o < depth_of(t));
            if (en[p] && we[p] && ok) ref_mem[t][o] = dd[p];
        end
        req_en = en; req_we = we;
        req_ptr[0] = p0; req_ptr[1] = p1;
        req_wdata[0] = d0; req_wdata[1] = d1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(2'b00, 2'b00, '0, '0, '0, '0, "", "");
    endtask

    task automatic lf_adv();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    initial begin
        for (int p = 0; p < NP; p++) begin
            e1_v[p] = 1'b0; e1_d[p] = '0; e1_l[p] = "";
            e2_v[p] = 1'b0; e2_d[p] = '0; e2_l[p] = "";
        end
        for (int m = 0; m < NM; m++)
            for (int o = 0; o < MD; o++) ref_mem[m][o] = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            n_cmp++; if (rsp_valid[p] !== 1'b0) fail("R1 valid in reset", p, DW'(rsp_valid[p]), '0);
            n_cmp++; if (rsp_rdata[p] !== '0)  fail("R1 data in reset", p, rsp_rdata[p], '0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            n_cmp++; if (rsp_valid[p] !== 1'b0) fail("R1 valid after reset", p, DW'(rsp_valid[p]), '0);
            n_cmp++; if (rsp_rdata[p] !== '0)  fail("R1 data after reset", p, rsp_rdata[p], '0);
        end

        // R2: fill every pointer value from port 0 (out-of-range ones ignored)
        for (int i = 0; i < 64; i++)
            step(2'b01, 2'b01, PW'(i), '0, DW'(i * 37 + 5), '0, "", "");
        idle(2);

        // R2 / R7: plain sweep, both ports reading
        for (int i = 0; i < 64; i++)
            step(2'b11, 2'b00, PW'(i), PW'(63 - i), '0, '0, "R2 sweep read", "R7 dual read");
        idle(2);

        // R4: tag changes every cycle on each port
        for (int o = 0; o < MD; o++)
            for (int t = 0; t < 4; t++)
                step(2'b11, 2'b00, PW'({t[1:0], o[3:0]}), PW'({t[1:0] + 2'd1, o[3:0]}),
                     '0, '0, "R4 tag switch", "R4 tag switch");
        idle(2);

        // R3: rewrite memory 0, then other memories must hold their data
        for (int o = 0; o < 16; o++)
            step(2'b01, 2'b01, PW'({2'd0, o[3:0]}), '0, DW'(o * 11 + 200), '0, "", "");
        for (int o = 0; o < 8; o++)
            step(2'b11, 2'b00, PW'({2'd1, o[3:0]}), PW'({2'd2, o[3:0]}), '0, '0,
                 "R3 other mem kept", "R3 other mem kept");
        idle(2);

        // R8: write on one port, read same pointer on the other
        for (int t = 0; t < NM; t++)
            for (int o = 0; o < 4; o++) begin
                step(2'b11, 2'b10, PW'({t[1:0], o[3:0]}), PW'({t[1:0], o[3:0]}),
                     '0, DW'(t * 50 + o + 1), "R8 read old", "");
                step(2'b11, 2'b01, PW'({t[1:0], o[3:0]}), PW'({t[1:0], o[3:0]}),
                     DW'(t * 50 + o + 100), '0, "", "R8 read old");
                step(2'b01, 2'b00, PW'({t[1:0], o[3:0]}), '0, '0, '0, "R8 write landed", "");
            end
        idle(2);

        // R9: both ports write the same pointer
        for (int t = 0; t < NM; t++) begin
            step(2'b11, 2'b11, PW'({t[1:0], 4'd2}), PW'({t[1:0], 4'd2}),
                 8'h5A, DW'(8'hC0 + t), "", "");
            step(2'b11, 2'b00, PW'({t[1:0], 4'd2}), PW'({t[1:0], 4'd2}),
                 '0, '0, "R9 port1 wins", "R9 port1 wins");
        end
        idle(2);

        // R10 / R11: out-of-range writes must not alias onto real slots
        for (int o = 4; o < 16; o++)
            step(2'b11, 2'b11, PW'({2'd2, o[3:0]}), PW'({2'd3, o[3:0]}), 8'hEE, 8'hDD, "", "");
        for (int o = 8; o < 16; o++)
            step(2'b01, 2'b01, PW'({2'd1, o[3:0]}), '0, 8'hBB, '0, "", "");
        for (int o = 0; o < 16; o++)
            step(2'b11, 2'b00, PW'({2'd2, o[3:0]}), PW'({2'd1, o[3:0]}), '0, '0,
                 "R10 slot kept", "R10 slot kept");
        for (int o = 0; o < 16; o++)
            step(2'b11, 2'b00, PW'({2'd3, o[3:0]}), PW'({2'd0, o[3:0]}), '0, '0,
                 "R11 tag3", "R11 slot kept");
        idle(2);

        // R7: pseudo-random mix with forced collisions
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] en, we;
            logic [PW-1:0] a0, a1;
            lf_adv();
            en = lf[1:0]; we = lf[3:2]; a0 = lf[9:4]; a1 = lf[15:10];
            if (i % 4 == 0) a1 = a0;
            lf_adv();
            step(en, we, a0, a1, lf[7:0], lf[15:8], "R7 random", "R7 random");
        end
        idle(3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule